// File: doc/BRIEF.md
# Tiled Multi-Dimensional Address Sequencer

This block drives the address side of a DMA engine that moves data between a flat memory and a stream. It treats the memory as a buffer of up to four dimensions, where dimension 0 is contiguous. Software supplies the following configuration:

- the buffer extent and the tile extent in each dimension;
- a signed starting coordinate, which may be negative;
- an optional data boundary;
- up to four inter-tile traversal loops, each giving the dimension it steps, a stride and a wrap count;
- a repetition count.

When `start` is asserted the block captures the configuration. It then emits one element per accepted handshake until the whole traversal is complete.

For each element the block emits a linear address and a pad flag. A set pad flag marks a position outside the real data region, and the read path must return zero for it. The number of dimensions is a parameter, so the same code also builds the reduced three-dimension variant. Loop entries whose wrap is 1 are neutral, and so are dimensions whose buffer and tile extents are 1.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset `outValid`, `outLast` and `done` are 0. A `start` pulse while idle captures every configuration input, and `outValid` is 1 from the next cycle.
- R2: Inside a tile, elements are visited with dimension 0 varying fastest, then dimension 1, then higher dimensions. The address of a non-padded element is the sum of coord[d]*pitch[d], where pitch[0]=1 and pitch[d]=pitch[d-1]*buf[d-1]. Field d of each per-dimension bus sits at bits [d*W +: W].
- R3: Loop entry 0 is the innermost loop. Each step of loop i adds its stride to the tile origin of the dimension it names. After `wrap` positions the loop returns to 0 and carries into loop i+1, and the traversal ends when the outermost loop finishes. A wrap of 0 counts as 1, and so does a tile extent of 0.
- R4: The loops may name dimensions in any order, for example dimension 1 innermost and dimension 0 outer. The loop-dimension field of entry i sits at bits [i*2 +: 2].
- R5: The offset is a signed two's-complement coordinate for each dimension. An element with any negative coordinate has `outPad`=1 and `outAddr`=0.
- R6: An element with any coordinate at or beyond the buffer extent of its dimension has `outPad`=1 and `outAddr`=0.
- R7: A nonzero boundary value smaller than the buffer extent lowers the limit of its dimension. Coordinates at or beyond that value are padding. A boundary value of 0 means no boundary.
- R8: The full traversal is replayed `cfgRepeat` times, and a value of 0 gives one pass.
- R9: While `outValid`=1 and `outReady`=0, `outAddr`, `outPad` and `outLast` hold steady. The sequence advances only on a cycle where both are 1.
- R10: `outLast` is 1 only on the final element of the final repetition. After that element is accepted, `done` is 1 for exactly one cycle and `outValid` returns to 0.
- R11: `start` and changes on the configuration inputs have no effect while a traversal is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture configuration and begin traversal |
| cfgBufDim | input | NDIM*DW | Buffer extent for each dimension |
| cfgTileDim | input | NDIM*DW | Tile extent for each dimension |
| cfgOffset | input | NDIM*OW | Signed start coordinate for each dimension |
| cfgBound | input | NDIM*DW | Data boundary for each dimension, 0 = none |
| cfgLoopDim | input | NLOOP*2 | Dimension stepped by each loop |
| cfgLoopStride | input | NLOOP*SW | Stride of each loop in elements |
| cfgLoopWrap | input | NLOOP*DW | Number of positions of each loop |
| cfgRepeat | input | RW | Number of traversal passes |
| outValid | output | 1 | Element available |
| outReady | input | 1 | Consumer accepts element |
| outAddr | output | AW | Linear element address |
| outPad | output | 1 | Element is padding (deliver zero) |
| outLast | output | 1 | Final element of the run |
| done | output | 1 | One-cycle pulse after the final element |

## Verification
A wrong carry in the element or loop counters shows up on the very next accepted handshake, as an address that departs from the expected sequence. A stuck counter instead changes the element count, and with it the position of `outLast` and the cycle of `done`. Faults in the coordinate sum or the limit registers appear as a pad flag or address mismatch at the first element that crosses a buffer or boundary edge. That is why the scenarios place edges at both ends of a dimension. A repetition counter that is off by one moves `done` by a whole traversal, and this is detected at the end of the run.

// File: rtl/tag_pkg.sv
package tag_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic restart;
  } tagStrb_t;

  typedef enum logic {ST_IDLE, ST_RUN} tagState_e;
endpackage

// File: rtl/tag_ctrl.sv
module tag_ctrl
  import tag_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [RW-1:0] cfgRepeat,
  input  logic          outReady,
  input  logic          isFinal,
  output tagStrb_t      strb,
  output logic          outValid,
  output logic          outLast,
  output logic          done
);
  tagState_e state;
  logic [RW-1:0] repLeft;
  logic fire;

  assign outValid = (state == ST_RUN);
  assign fire     = outValid && outReady;
  assign outLast  = outValid && isFinal && (repLeft == '0);

  always_comb begin
    strb = '0;
    if (state == ST_IDLE && start) strb.load = 1'b1;
    if (fire) begin
      if (!isFinal)              strb.step    = 1'b1;
      else if (repLeft != '0)    strb.restart = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      repLeft <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          repLeft <= (cfgRepeat == '0) ? '0 : cfgRepeat - 1'b1;
        end
        ST_RUN: if (fire && isFinal) begin
          if (repLeft != '0) repLeft <= repLeft - 1'b1;
          else begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && start) |=> outValid); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> (done && !outValid)); // R10
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && start && !(outReady && outLast)) |=> outValid); // R11
  AST_REP_NONINCREASING: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (repLeft <= $past(repLeft))); // R8
endmodule

// File: rtl/tag_dpath.sv
module tag_dpath
  import tag_pkg::*;
#(
  parameter int NDIM  = 4,
  parameter int NLOOP = 4,
  parameter int DW    = 8,
  parameter int OW    = 10,
  parameter int SW    = 10,
  parameter int AW    = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  tagStrb_t          strb,
  input  logic [NDIM*DW-1:0]  cfgBufDim,
  input  logic [NDIM*DW-1:0]  cfgTileDim,
  input  logic [NDIM*OW-1:0]  cfgOffset,
  input  logic [NDIM*DW-1:0]  cfgBound,
  input  logic [NLOOP*2-1:0]  cfgLoopDim,
  input  logic [NLOOP*SW-1:0] cfgLoopStride,
  input  logic [NLOOP*DW-1:0] cfgLoopWrap,
  output logic              isFinal,
  output logic [AW-1:0]     outAddr,
  output logic              outPad
);
  localparam int CRW = DW + SW + 4;

  logic [DW-1:0]        bufR    [NDIM];
  logic [DW-1:0]        tileR   [NDIM];
  logic [DW-1:0]        limR    [NDIM];
  logic signed [OW-1:0] offR    [NDIM];
  logic [AW-1:0]        pitchR  [NDIM];
  logic [AW-1:0]        pitchNx [NDIM];
  logic [1:0]           lDimR   [NLOOP];
  logic [SW-1:0]        lStrR   [NLOOP];
  logic [DW-1:0]        lWrapR  [NLOOP];
  logic [DW-1:0]        elemCnt [NDIM];
  logic [DW-1:0]        loopCnt [NLOOP];
  logic                 elemEnd [NDIM];
  logic                 loopEnd [NLOOP];
  logic                 elemCy  [NDIM+1];
  logic                 loopCy  [NLOOP+1];
  logic signed [CRW-1:0] coord  [NDIM];
  logic [AW-1:0]        totalR;
  logic [AW-1:0]        addrSum;
  logic                 padAny;

  always_comb begin
    pitchNx[0] = AW'(1);
    for (int d = 1; d < NDIM; d++)
      pitchNx[d] = pitchNx[d-1] * AW'(cfgBufDim[(d-1)*DW +: DW]);
  end

  // carry chains: elements first, then loops from innermost outward
  always_comb begin
    elemCy[0] = 1'b1;
    for (int d = 0; d < NDIM; d++) begin
      elemEnd[d]  = ((DW+1)'(elemCnt[d]) + 1'b1) >= (DW+1)'(tileR[d]);
      elemCy[d+1] = elemCy[d] && elemEnd[d];
    end
    loopCy[0] = elemCy[NDIM];
    for (int i = 0; i < NLOOP; i++) begin
      loopEnd[i]  = ((DW+1)'(loopCnt[i]) + 1'b1) >= (DW+1)'(lWrapR[i]);
      loopCy[i+1] = loopCy[i] && loopEnd[i];
    end
  end
  assign isFinal = loopCy[NLOOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < NDIM; d++) begin
        bufR[d] <= '0; tileR[d] <= '0; limR[d] <= '0;
        offR[d] <= '0; pitchR[d] <= '0; elemCnt[d] <= '0;
      end
      for (int i = 0; i < NLOOP; i++) begin
        lDimR[i] <= '0; lStrR[i] <= '0; lWrapR[i] <= '0; loopCnt[i] <= '0;
      end
      totalR <= '0;
    end else if (strb.load) begin
      for (int d = 0; d < NDIM; d++) begin
        bufR[d]    <= cfgBufDim[d*DW +: DW];
        tileR[d]   <= cfgTileDim[d*DW +: DW];
        offR[d]    <= cfgOffset[d*OW +: OW];
        pitchR[d]  <= pitchNx[d];
        limR[d]    <= (cfgBound[d*DW +: DW] != '0 &&
                       cfgBound[d*DW +: DW] < cfgBufDim[d*DW +: DW]) ?
                      cfgBound[d*DW +: DW] : cfgBufDim[d*DW +: DW];
        elemCnt[d] <= '0;
      end
      for (int i = 0; i < NLOOP; i++) begin
        lDimR[i]   <= cfgLoopDim[i*2 +: 2];
        lStrR[i]   <= cfgLoopStride[i*SW +: SW];
        lWrapR[i]  <= cfgLoopWrap[i*DW +: DW];
        loopCnt[i] <= '0;
      end
      totalR <= pitchNx[NDIM-1] * AW'(cfgBufDim[(NDIM-1)*DW +: DW]);
    end else if (strb.restart) begin
      for (int d = 0; d < NDIM; d++) elemCnt[d] <= '0;
      for (int i = 0; i < NLOOP; i++) loopCnt[i] <= '0;
    end else if (strb.step) begin
      for (int d = 0; d < NDIM; d++)
        if (elemCy[d]) elemCnt[d] <= elemEnd[d] ? '0 : elemCnt[d] + 1'b1;
      for (int i = 0; i < NLOOP; i++)
        if (loopCy[i]) loopCnt[i] <= loopEnd[i] ? '0 : loopCnt[i] + 1'b1;
    end
  end

  // coordinate = offset + element index + contributions of loops on that dimension
  always_comb begin
    padAny  = 1'b0;
    addrSum = '0;
    for (int d = 0; d < NDIM; d++) begin
      coord[d] = CRW'(offR[d]) + $signed(CRW'(elemCnt[d]));
      for (int i = 0; i < NLOOP; i++)
        if (int'(lDimR[i]) == d)
          coord[d] = coord[d] + $signed(CRW'(loopCnt[i]) * CRW'(lStrR[i]));
      if (coord[d] < 0 || coord[d] >= $signed(CRW'(limR[d]))) padAny = 1'b1;
      addrSum = addrSum + pitchR[d] * AW'(coord[d][DW-1:0]);
    end
  end

  assign outPad  = padAny;
  assign outAddr = padAny ? '0 : addrSum;

  for (genvar g = 0; g < NDIM; g++) begin : gElemChk
    AST_ELEM_IN_TILE: assert property (@(posedge clk) disable iff (!rstN)
      (tileR[g] != '0) |-> (elemCnt[g] < tileR[g])); // R2
  end
  for (genvar g = 0; g < NLOOP; g++) begin : gLoopChk
    AST_LOOP_IN_WRAP: assert property (@(posedge clk) disable iff (!rstN)
      (lWrapR[g] != '0) |-> (loopCnt[g] < lWrapR[g])); // R3
  end
  AST_ADDR_INSIDE_BUFFER: assert property (@(posedge clk) disable iff (!rstN)
    !outPad |-> (outAddr < totalR)); // R6
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tag_pkg::*;
#(
  parameter int NDIM  = 4,
  parameter int NLOOP = 4,
  parameter int DW    = 8,
  parameter int OW    = 10,
  parameter int SW    = 10,
  parameter int RW    = 8,
  parameter int AW    = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [NDIM*DW-1:0]  cfgBufDim,
  input  logic [NDIM*DW-1:0]  cfgTileDim,
  input  logic [NDIM*OW-1:0]  cfgOffset,
  input  logic [NDIM*DW-1:0]  cfgBound,
  input  logic [NLOOP*2-1:0]  cfgLoopDim,
  input  logic [NLOOP*SW-1:0] cfgLoopStride,
  input  logic [NLOOP*DW-1:0] cfgLoopWrap,
  input  logic [RW-1:0]       cfgRepeat,
  output logic                outValid,
  input  logic                outReady,
  output logic [AW-1:0]       outAddr,
  output logic                outPad,
  output logic                outLast,
  output logic                done
);
  tagStrb_t strb;
  logic isFinal;

  tag_ctrl #(.RW(RW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgRepeat(cfgRepeat),
    .outReady(outReady), .isFinal(isFinal), .strb(strb),
    .outValid(outValid), .outLast(outLast), .done(done)
  );

  tag_dpath #(.NDIM(NDIM), .NLOOP(NLOOP), .DW(DW), .OW(OW), .SW(SW), .AW(AW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgBufDim(cfgBufDim), .cfgTileDim(cfgTileDim), .cfgOffset(cfgOffset),
    .cfgBound(cfgBound), .cfgLoopDim(cfgLoopDim), .cfgLoopStride(cfgLoopStride),
    .cfgLoopWrap(cfgLoopWrap), .isFinal(isFinal), .outAddr(outAddr), .outPad(outPad)
  );

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAddr) &&
                                 $stable(outPad) && $stable(outLast))); // R9
endmodule

// File: tb/tile_addr_gen_tb.sv
module tile_addr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDIM = 4, NLOOP = 4, DW = 8, OW = 10, SW = 10, RW = 8, AW = 24;
  localparam int MAXE = 1024;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, outReady = 1'b0;
  logic [NDIM*DW-1:0]  cfgBufDim = '0, cfgTileDim = '0, cfgBound = '0;
  logic [NDIM*OW-1:0]  cfgOffset = '0;
  logic [NLOOP*2-1:0]  cfgLoopDim = '0;
  logic [NLOOP*SW-1:0] cfgLoopStride = '0;
  logic [NLOOP*DW-1:0] cfgLoopWrap = '0;
  logic [RW-1:0]       cfgRepeat = '0;
  logic outValid, outPad, outLast, done;
  logic [AW-1:0] outAddr;

  int nChecks = 0, nFail = 0;
  int bD[NDIM], tD[NDIM], oD[NDIM], bnD[NDIM];
  int lDm[NLOOP], lSt[NLOOP], lWr[NLOOP], repN;
  int expAddr[MAXE];
  bit expPad[MAXE];
  int expN;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_addr_gen #(.NDIM(NDIM), .NLOOP(NLOOP), .DW(DW), .OW(OW), .SW(SW), .RW(RW), .AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgBufDim(cfgBufDim), .cfgTileDim(cfgTileDim), .cfgOffset(cfgOffset),
    .cfgBound(cfgBound), .cfgLoopDim(cfgLoopDim), .cfgLoopStride(cfgLoopStride),
    .cfgLoopWrap(cfgLoopWrap), .cfgRepeat(cfgRepeat),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr),
    .outPad(outPad), .outLast(outLast), .done(done)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearCfg();
    for (int d = 0; d < NDIM; d++) begin bD[d] = 1; tD[d] = 1; oD[d] = 0; bnD[d] = 0; end
    for (int i = 0; i < NLOOP; i++) begin lDm[i] = 0; lSt[i] = 0; lWr[i] = 1; end
    repN = 1;
  endtask

  task automatic driveCfg();
    for (int d = 0; d < NDIM; d++) begin
      cfgBufDim[d*DW +: DW]  = DW'(bD[d]);
      cfgTileDim[d*DW +: DW] = DW'(tD[d]);
      cfgBound[d*DW +: DW]   = DW'(bnD[d]);
      cfgOffset[d*OW +: OW]  = OW'(oD[d]);
    end
    for (int i = 0; i < NLOOP; i++) begin
      cfgLoopDim[i*2 +: 2]     = 2'(lDm[i]);
      cfgLoopStride[i*SW +: SW] = SW'(lSt[i]);
      cfgLoopWrap[i*DW +: DW]  = DW'(lWr[i]);
    end
    cfgRepeat = RW'(repN);
  endtask

  // independent reference model: nested odometers over repetitions, loops, tile elements
  task automatic buildExp();
    int pitch[NDIM], lim[NDIM], ec[NDIM], lc[NLOOP], c, addr, reps;
    bit pad, carry, lDone, eDone;
    pitch[0] = 1;
    for (int d = 1; d < NDIM; d++) pitch[d] = pitch[d-1] * bD[d-1];
    for (int d = 0; d < NDIM; d++) lim[d] = (bnD[d] != 0 && bnD[d] < bD[d]) ? bnD[d] : bD[d];
    reps = (repN == 0) ? 1 : repN;
    expN = 0;
    for (int r = 0; r < reps; r++) begin
      for (int i = 0; i < NLOOP; i++) lc[i] = 0;
      lDone = 0;
      while (!lDone) begin
        for (int d = 0; d < NDIM; d++) ec[d] = 0;
        eDone = 0;
        while (!eDone) begin
          pad = 0; addr = 0;
          for (int d = 0; d < NDIM; d++) begin
            c = oD[d] + ec[d];
            for (int i = 0; i < NLOOP; i++) if (lDm[i] == d) c += lc[i] * lSt[i];
            if (c < 0 || c >= lim[d]) pad = 1;
            addr += c * pitch[d];
          end
          if (expN < MAXE) begin
            expAddr[expN] = pad ? 0 : addr;
            expPad[expN]  = pad;
          end
          expN++;
          carry = 1;
          for (int d = 0; d < NDIM; d++)
            if (carry) begin
              if (ec[d] + 1 >= tD[d]) ec[d] = 0; else begin ec[d]++; carry = 0; end
            end
          eDone = carry;
        end
        carry = 1;
        for (int i = 0; i < NLOOP; i++)
          if (carry) begin
            if (lc[i] + 1 >= lWr[i]) lc[i] = 0; else begin lc[i]++; carry = 0; end
          end
        lDone = carry;
      end
    end
  endtask

  // readyMode 0: always ready; 1: stall every third cycle. disturb: start + config change mid-run
  task automatic runScenario(string req, int readyMode, bit disturb);
    int idx = 0, cyc = 0;
    bit r, disturbed = 0;
    logic [AW-1:0] stallAddr;
    bit stallPad, stalled = 0;
    buildExp();
    driveCfg();
    @(negedge clk); start = 1'b1;
    while (idx < expN && cyc < 20000) begin
      @(negedge clk);
      start = 1'b0;
      if (stalled) begin
        chk(outValid && outAddr == stallAddr && outPad == stallPad, "R9", "held under stall",
            longint'(outAddr), longint'(stallAddr));
        stalled = 0;
      end
      r = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 1);
      outReady = r;
      if (disturb && idx == 5 && !disturbed) begin
        start = 1'b1;
        cfgTileDim = '1; cfgBufDim = '1; cfgRepeat = '0; cfgOffset = '0;
        disturbed = 1;
      end
      #1;
      if (outValid && r) begin
        chk(outAddr == AW'(expAddr[idx]) && outPad == expPad[idx], req,
            $sformatf("element %0d addr/pad(pad exp %0d)", idx, expPad[idx]),
            longint'(outAddr), longint'(expAddr[idx]));
        chk(outLast == (idx == expN - 1), "R10", $sformatf("last flag at element %0d", idx),
            longint'(outLast), longint'(idx == expN - 1));
        idx++;
      end else if (outValid) begin
        stallAddr = outAddr; stallPad = outPad; stalled = 1;
      end
      cyc++;
    end
    chk(idx == expN, "R3", "elements delivered", idx, expN);
    @(negedge clk); outReady = 1'b0; start = 1'b0;
    chk(done == 1'b1 && outValid == 1'b0, "R10", "done after final element", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done lasts one cycle", done, 0);
  endtask

  task automatic testReset();
    chk(outValid == 1'b0, "R1", "valid at reset", outValid, 0);
    chk(done == 1'b0 && outLast == 1'b0, "R1", "done/last at reset", done, 0);
  endtask

  task automatic testTileGrid();   // R2 R3: 10x6 buffer, 3x2 tiles, 2x3 grid
    clearCfg();
    bD[0] = 10; bD[1] = 6; tD[0] = 3; tD[1] = 2;
    lDm[0] = 0; lSt[0] = 3; lWr[0] = 2;
    lDm[1] = 1; lSt[1] = 2; lWr[1] = 3;
    buildExp();
    chk(expN == 36, "R3", "model count for 6 tiles of 6", expN, 36);
    runScenario("R2 R3", 0, 0);
  endtask

  task automatic testSwapOrder();  // R4: dimension 1 innermost
    clearCfg();
    bD[0] = 10; bD[1] = 6; tD[0] = 2; tD[1] = 3; oD[0] = 6;
    lDm[0] = 1; lSt[0] = 3; lWr[0] = 2;
    lDm[1] = 0; lSt[1] = 2; lWr[1] = 2;
    runScenario("R4", 0, 0);
  endtask

  task automatic testNegOffset();  // R5 R6: 1D, pads on both ends
    clearCfg();
    bD[0] = 16; tD[0] = 20; oD[0] = -2; lSt[0] = 20; lWr[0] = 1;
    runScenario("R5 R6", 0, 0);
  endtask

  task automatic testBoundary();   // R7: boundary 10 in a 16 buffer
    clearCfg();
    bD[0] = 16; bnD[0] = 10; tD[0] = 8; oD[0] = -2; lSt[0] = 9; lWr[0] = 2;
    runScenario("R7", 0, 0);
  endtask

  task automatic testHalo3d();     // R2 R5 R6: 3D buffer with a one-element halo
    clearCfg();
    bD[0] = 4; bD[1] = 3; bD[2] = 2;
    tD[0] = 6; tD[1] = 5; tD[2] = 2;
    oD[0] = -1; oD[1] = -1;
    runScenario("R2 R5 R6", 0, 0);
  endtask

  task automatic testRepeatStall(); // R8 R9 R11
    clearCfg();
    bD[0] = 5; bD[1] = 4; tD[0] = 2; tD[1] = 2;
    lDm[0] = 0; lSt[0] = 2; lWr[0] = 2;
    lDm[1] = 1; lSt[1] = 2; lWr[1] = 2;
    repN = 3;
    runScenario("R8 R9 R11", 1, 1);
  endtask

  task automatic testRepZero();    // R8 R3: repeat 0 and wrap 0 both give one pass
    clearCfg();
    bD[0] = 6; bD[1] = 2; tD[0] = 3; tD[1] = 2;
    lDm[0] = 0; lSt[0] = 3; lWr[0] = 2;
    lDm[1] = 1; lSt[1] = 1; lWr[1] = 0;
    repN = 0;
    runScenario("R8 R3", 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    clearCfg();
    driveCfg();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTileGrid();
    testSwapOrder();
    testNegOffset();
    testBoundary();
    testHalo3d();
    testRepeatStall();
    testRepZero();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule